// File: doc/BRIEF.md
# Pixel-Doubled Framebuffer Scan-Out

This block drives a 640x480 raster at a 60 Hz frame rate from a 320x240 image held in an external synchronous-read memory, one byte per pixel. Each stored pixel is repeated on two adjacent screen pixels and on two adjacent screen lines, so the small image fills the whole screen. The memory address comes straight from the upper bits of the horizontal and vertical scan counters, with a fixed row pitch of 512 bytes. Row 0 of the image therefore starts at byte 0, row 1 at byte 512, and so on.

Each byte holds a colour packed as three red bits, three green bits and two blue bits. The byte returned by the memory is captured in a register on the pixel clock and then split into the three colour outputs. Horizontal and vertical sync come from set/clear registers. These registers are set and cleared by decoded counter values and delayed so that they line up with the colour pipeline. Outside the visible window the colour outputs are zero.

All porch, sync and visible lengths are parameters. The defaults give standard 640x480 timing with a 25 MHz pixel clock.

Top module: `vga_scaled_scanout`

## Requirements
- R1: The horizontal counter runs from 0 to H_TOTAL-1 (800 by default). `hsync_o` is low for exactly H_SYNC pixel clocks (96 by default), starting at count H_VIS+H_FP (656 by default).
- R2: The vertical counter advances once per line and runs from 0 to V_TOTAL-1 (525 by default). `vsync_o` is low for exactly V_SYNC whole lines (2 by default), starting at line V_VIS+V_FP (490 by default).
- R3: When the screen position is outside the visible window (x >= H_VIS or y >= V_VIS), `red_o`, `green_o` and `blue_o` are all zero.
- R4: In the visible window the colour outputs split the fetched byte: red is bits 7:5, green is bits 4:2, blue is bits 1:0.
- R5: Screen pixel (x, y) shows the byte stored at address (y/2)*512 + x/2. Each stored pixel therefore covers a 2x2 block of screen pixels.
- R6: `mem_addr_o` is combinational from the current counters and equals {y[8:1], x[9:1]}. This is 17 bits: 8 row bits above 9 column bits, so all 240 source rows get their own address.
- R7: The memory returns data one clock after the address. The colour outputs, `hsync_o` and `vsync_o` all lag the counter position by exactly two clocks, so sync and colour stay aligned.
- R8: While `rst_ni` is low, both sync outputs are high and all colour outputs are zero. After release, the counters start at position (0, 0).
- R9: Successive falling edges of `vsync_o` are H_TOTAL*V_TOTAL clocks apart (420000 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 17 | Framebuffer read address {row, column} |
| mem_data_i | input | 8 | Framebuffer read data, valid one clock after the address |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| red_o | output | 3 | Red level |
| green_o | output | 3 | Green level |
| blue_o | output | 2 | Blue level |

## Verification
Several events share a single clock edge at the end of each line. The horizontal wrap, the vertical step and the edge of the visibility window all fall there, and on the last line the frame wrap does too. At the same time, the pipeline is still shifting out the last visible pixel and the first blanking pixel. The bench uses a reduced timing set so that several whole frames pass through every one of these coincidences. For every clock it forms an expected sync, colour and address item from the screen position alone, and compares it against the outputs two clocks later. A misaligned delay stage or a wrong decode shows up as a mismatch at exactly those boundary cycles. Pulse widths and the frame period are measured separately, from the output edges.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } rgb332_t;

endpackage

// File: rtl/vga_timing_counter.sv
module vga_timing_counter #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcount_o,
  output logic [VW-1:0] vcount_o
);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          line_end;

  assign line_end = (h_q == HW'(H_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign hcount_o = h_q;
  assign vcount_o = v_q;

  p_h_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q < HW'(H_TOTAL));

  p_v_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q < VW'(V_TOTAL));

  // rows only move on the line wrap
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end |=> $stable(v_q));

endmodule

// File: rtl/vga_setclr_pipe.sv
// Set/clear flag decoded from a counter, followed by LAT-1 delay stages.
module vga_setclr_pipe #(
  parameter int W      = 10,
  parameter int SET_AT = 0,
  parameter int CLR_AT = 1,
  parameter int LAT    = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  output logic         flag_o
);

  logic [LAT-1:0] stg_q;
  logic           nxt;

  always_comb begin
    nxt = stg_q[0];
    if (cnt_i == W'(SET_AT))      nxt = 1'b1;
    else if (cnt_i == W'(CLR_AT)) nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= LAT'({stg_q, nxt});
  end

  assign flag_o = stg_q[LAT-1];

endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
  import vga_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vis_i,
  input  logic [7:0] data_i,
  output logic [2:0] red_o,
  output logic [2:0] green_o,
  output logic [1:0] blue_o
);

  rgb332_t pix_q;

  // capture register: fetched byte, or black while blanked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pix_q <= '0;
    else if (vis_i) pix_q <= rgb332_t'(data_i);
    else            pix_q <= '0;
  end

  assign red_o   = pix_q.r;
  assign green_o = pix_q.g;
  assign blue_o  = pix_q.b;

  p_field_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_i |=> (red_o == $past(data_i[7:5]) && green_o == $past(data_i[4:2])
               && blue_o == $past(data_i[1:0])));

endmodule

// File: rtl/vga_scaled_scanout.sv
module vga_scaled_scanout #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [COL_W+ROW_W-1:0] mem_addr_o,
  input  logic [7:0]             mem_data_i,
  output logic                   hsync_o,
  output logic                   vsync_o,
  output logic [2:0]             red_o,
  output logic [2:0]             green_o,
  output logic [1:0]             blue_o
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int HS_ON   = H_VIS + H_FP;
  localparam int HS_OFF  = HS_ON + H_SYNC;
  localparam int VS_ON   = V_VIS + V_FP;
  localparam int VS_OFF  = VS_ON + V_SYNC;
  // memory read + capture register
  localparam int PIPE    = 2;

  logic [HW-1:0]    hcount;
  logic [VW-1:0]    vcount;
  logic [COL_W-1:0] col_idx;
  logic [ROW_W-1:0] row_idx;
  logic             h_vis1, v_vis1, hs_act, vs_act;

  vga_timing_counter #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_cnt (
    .clk_i, .rst_ni, .hcount_o(hcount), .vcount_o(vcount)
  );

  // each source pixel spans two columns and two lines
  assign col_idx    = COL_W'(hcount >> 1);
  assign row_idx    = ROW_W'(vcount >> 1);
  assign mem_addr_o = {row_idx, col_idx};

  // visibility feeds the capture gate: one stage, level with returned data
  vga_setclr_pipe #(.W(HW), .SET_AT(0), .CLR_AT(H_VIS), .LAT(PIPE-1)) u_hvis (
    .clk_i, .rst_ni, .cnt_i(hcount), .flag_o(h_vis1)
  );
  vga_setclr_pipe #(.W(VW), .SET_AT(0), .CLR_AT(V_VIS), .LAT(PIPE-1)) u_vvis (
    .clk_i, .rst_ni, .cnt_i(vcount), .flag_o(v_vis1)
  );

  // sync flags: full pipeline depth so they leave with the colour
  vga_setclr_pipe #(.W(HW), .SET_AT(HS_ON), .CLR_AT(HS_OFF), .LAT(PIPE)) u_hs (
    .clk_i, .rst_ni, .cnt_i(hcount), .flag_o(hs_act)
  );
  vga_setclr_pipe #(.W(VW), .SET_AT(VS_ON), .CLR_AT(VS_OFF), .LAT(PIPE)) u_vs (
    .clk_i, .rst_ni, .cnt_i(vcount), .flag_o(vs_act)
  );

  assign hsync_o = ~hs_act;
  assign vsync_o = ~vs_act;

  vga_pixel_out u_pix (
    .clk_i, .rst_ni,
    .vis_i(h_vis1 & v_vis1),
    .data_i(mem_data_i),
    .red_o, .green_o, .blue_o
  );

  p_hsync_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> ($past(hcount, 2) >= HW'(HS_ON) && $past(hcount, 2) < HW'(HS_OFF)));

  p_vsync_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> ($past(vcount, 2) >= VW'(VS_ON) && $past(vcount, 2) < VW'(VS_OFF)));

  p_blank_black_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hcount, 2) >= HW'(H_VIS) || $past(vcount, 2) >= VW'(V_VIS))
      |-> ({red_o, green_o, blue_o} == 8'h00));

  p_sync_in_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_o || !vsync_o) |-> ({red_o, green_o, blue_o} == 8'h00));

endmodule

// File: tb/vga_scaled_scanout_tb.sv
module vga_scaled_scanout_tb;

  localparam int HV = 32, HF = 4, HS = 8, HB = 4;
  localparam int VV = 24, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       vis;
    logic [7:0] rgb;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] addr;
  logic [7:0]  mem_q = 8'h00;
  logic        hsync, vsync;
  logic [2:0]  red, green;
  logic [1:0]  blue;

  always #4 clk = ~clk;

  vga_scaled_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_data_i(mem_q),
    .hsync_o(hsync), .vsync_o(vsync), .red_o(red), .green_o(green), .blue_o(blue)
  );

  function automatic logic [7:0] pix_of(input int a);
    return 8'((a * 29) ^ (a >> 9) ^ (a >> 4));
  endfunction

  // synchronous-read framebuffer model
  always @(posedge clk) mem_q <= pix_of(int'(addr));

  int   vectors = 0, errs = 0;
  bit   run_en = 0, done = 0;
  int   pos;
  exp_t q[$];
  int   hs_len, vs_len, last_fall;
  bit   prev_vs;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      if (errs < 40) $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, pos, act, exp);
    end
  endtask

  function automatic exp_t model(input int p);
    exp_t e;
    int x, y;
    x = p % HT;
    y = (p / HT) % VT;
    e.hs  = !(x >= HV + HF && x < HV + HF + HS);
    e.vs  = !(y >= VV + VF && y < VV + VF + VS);
    e.vis = (x < HV) && (y < VV);
    e.rgb = e.vis ? pix_of((y / 2) * 512 + x / 2) : 8'h00;
    return e;
  endfunction

  function automatic exp_t idle();
    return '{hs: 1'b1, vs: 1'b1, vis: 1'b0, rgb: 8'h00};
  endfunction

  // driver side: load the pipeline with the two items ahead of position 1
  task automatic prime();
    q.delete();
    q.push_back(idle());
    q.push_back(model(0));
    pos = 1;
    hs_len = 0; vs_len = 0; last_fall = -1; prev_vs = 1'b1;
  endtask

  // per clock: push expected item for current position, pop the one due now
  always @(negedge clk) if (run_en) begin
    exp_t e;
    int x, y;
    x = pos % HT;
    y = (pos / HT) % VT;
    check("R6 addr", int'(addr), ((y / 2) % 256) * 512 + (x / 2) % 512);
    q.push_back(model(pos));
    e = q.pop_front();
    // two-clock alignment of sync and colour (R7)
    check("R1 hsync", int'(hsync), int'(e.hs));
    check("R2 vsync", int'(vsync), int'(e.vs));
    if (e.vis) check("R4 R5 colour", int'({red, green, blue}), int'(e.rgb));
    else       check("R3 blank", int'({red, green, blue}), 0);
    if (!hsync) hs_len++;
    else if (hs_len != 0) begin check("R1 width", hs_len, HS); hs_len = 0; end
    if (!vsync) vs_len++;
    else if (vs_len != 0) begin check("R2 width", vs_len, VS * HT); vs_len = 0; end
    if (prev_vs && !vsync) begin
      if (last_fall >= 0) check("R9 period", pos - last_fall, HT * VT);
      last_fall = pos;
    end
    prev_vs = vsync;
    pos++;
  end

  task automatic reset_checks();
    check("R8 hsync", int'(hsync), 1);
    check("R8 vsync", int'(vsync), 1);
    check("R8 colour", int'({red, green, blue}), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_checks();
    prime();
    rst_n = 1'b1;
    @(posedge clk);
    run_en = 1'b1;
    repeat (2 * HT * VT + 50) @(posedge clk);
    // reset in the middle of a frame
    run_en = 1'b0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    reset_checks();
    repeat (2) @(negedge clk);
    reset_checks();
    prime();
    rst_n = 1'b1;
    @(posedge clk);
    run_en = 1'b1;
    repeat (HT * VT + 10) @(posedge clk);
    run_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule